// File: doc/BRIEF.md
# Cascadable Synchronous Counter with Offset Ranges

The block is a binary up counter built from 4-bit stages that all change state on the rising clock edge. A low-active clear and a low-active parallel load are both synchronous. Counting needs two enables: `en_p` and `en_t`. Only `en_t` qualifies the carry output `rco`, and `rco` is high while the counter holds all ones. When the block has more than one stage, each stage's carry enables the stage above it, so the stages together act as one wider counter.

A parameter selects one of three operating modes:
- **Plain mode:** the counter behaves as described above.
- **Start-offset mode:** the carry is fed back into the load path. On the edge after the counter reaches all ones, it reloads the value on `d`. With `d` held at 0110, the counter cycles 0110 through 1111.
- **End-offset mode:** a decoded terminal value drives the synchronous clear. With the default terminal value of 1101, the counter cycles 0000 through 1101.

Top module: `offset_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` becomes all zeros. Clear takes priority over load, over counting and over both offset modes.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `d`. Bit 0 of `d` is the least significant bit. Load takes priority over counting.
- R3: When `clr_n` and `load_n` are high and both `en_p` and `en_t` are high, `q` increases by one at the edge. It wraps from all ones to all zeros.
- R4: When `clr_n` and `load_n` are high and either `en_p` or `en_t` is low, `q` keeps its value.
- R5: `rco` is high in the same cycle exactly when `q` is all ones and `en_t` is high. `en_p` has no effect on `rco`.
- R6: With `STAGES`=2, the upper 4 bits advance on the counting edge where the lower 4 bits are 1111. The 8-bit value wraps from 8'hFF to 8'h00.
- R7: With `MODE`=1 (start offset), a high `rco` at an edge loads `d`. With `d`=0110, the counter runs 0110..1111 and then returns to 0110.
- R8: With `MODE`=2 (end offset), `q` equal to `END_VAL` at an edge clears the counter, whatever the enables are. With `END_VAL`=13, the counter runs 0000..1101 and then returns to 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| d | input | 4*STAGES | Parallel load value; also the reload value in start-offset mode |
| q | output | 4*STAGES | Counter state |
| rco | output | 1 | Carry: all ones and `en_t` high |

## Verification
A wrong stored count shows at `q` in the cycle after the edge that caused it. The error then persists until the next clear or load, and it also shifts the moment `rco` rises. A corrupted carry path shows up differently:
- In a cascade, it leaves the upper nibble one step late.
- In start-offset mode, it makes the counter miss its reload and roll through 0000.
- In end-offset mode, a faulty terminal decode lets the count pass 1101 on the very next edge.

// File: rtl/offset_counter.sv
module offset_counter #(
  parameter int          STAGES  = 1,
  parameter int          MODE    = 0,
  parameter int unsigned END_VAL = 13
) (
  input  logic                  clk,
  input  logic                  clr_n,
  input  logic                  load_n,
  input  logic                  en_p,
  input  logic                  en_t,
  input  logic [4*STAGES-1:0]   d,
  output logic [4*STAGES-1:0]   q,
  output logic                  rco
);
  localparam int W = 4 * STAGES;
  localparam logic [W-1:0] END_Q = W'(END_VAL);

  logic [STAGES:0] carry;
  logic            clr_eff;
  logic            load_eff;

  assign carry[0] = en_t;
  assign rco      = carry[STAGES];

  generate
    if (MODE == 1) begin : g_start
      assign clr_eff  = clr_n;
      assign load_eff = load_n & ~carry[STAGES];
    end else if (MODE == 2) begin : g_end
      assign clr_eff  = clr_n & (q != END_Q);
      assign load_eff = load_n;
    end else begin : g_plain
      assign clr_eff  = clr_n;
      assign load_eff = load_n;
    end
  endgenerate

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [3:0] cnt;

      always_ff @(posedge clk) begin
        if (!clr_eff)
          cnt <= 4'h0;
        else if (!load_eff)
          cnt <= d[4*g +: 4];
        else if (en_p && carry[g])
          cnt <= cnt + 4'h1;
      end

      assign carry[g+1]  = carry[g] & (&cnt);
      assign q[4*g +: 4] = cnt;
    end
  endgenerate
endmodule

// File: rtl/offset_counter_chk.sv
module offset_counter_chk #(
  parameter int          STAGES  = 1,
  parameter int          MODE    = 0,
  parameter int unsigned END_VAL = 13
) (
  input logic                clk,
  input logic                clr_n,
  input logic                load_n,
  input logic                en_p,
  input logic                en_t,
  input logic [4*STAGES-1:0] d,
  input logic [4*STAGES-1:0] q,
  input logic                rco
);
  localparam int W = 4 * STAGES;
  localparam logic [W-1:0] END_Q = W'(END_VAL);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  logic forced;
  assign forced = (MODE == 1 && rco) || (MODE == 2 && q == END_Q);

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n && !(MODE == 2 && q == END_Q)) |=> q == $past(d));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && en_p && en_t && !forced) |=> q == $past(q) + 1'b1);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(en_p && en_t) && !forced) |=> $stable(q));

  // R5
  carry_full_chk: assert property (@(posedge clk) disable iff (!armed)
    rco |-> (&q) && en_t);

  // R5
  carry_gate_chk: assert property (@(posedge clk) disable iff (!armed)
    ((&q) && en_t) |-> rco);

  generate
    if (STAGES > 1) begin : g_casc
      // R6
      upper_step_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && en_p && en_t && !forced && q[3:0] == 4'hF)
          |=> q[7:4] == $past(q[7:4]) + 4'h1);
    end
    if (MODE == 1) begin : g_so
      // R7
      start_reload_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && rco) |=> q == $past(d));
    end
    if (MODE == 2) begin : g_eo
      // R8
      end_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        (q == END_Q) |=> q == '0);
    end
  endgenerate
endmodule

bind offset_counter offset_counter_chk #(
  .STAGES(STAGES), .MODE(MODE), .END_VAL(END_VAL)
) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
  .d(d), .q(q), .rco(rco)
);

// File: tb/tb_offset_counter.sv
module tb_offset_counter;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] d4 = 4'h0;
  logic [7:0] d8 = 8'h00;
  logic [3:0] q_pl, q_so, q_eo;
  logic [7:0] q_cs;
  logic       r_pl, r_so, r_eo, r_cs;

  offset_counter #(.STAGES(1), .MODE(0)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .d(d4), .q(q_pl), .rco(r_pl));
  offset_counter #(.STAGES(1), .MODE(1)) dut_so (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .d(d4), .q(q_so), .rco(r_so));
  offset_counter #(.STAGES(1), .MODE(2), .END_VAL(13)) dut_eo (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .d(d4), .q(q_eo), .rco(r_eo));
  offset_counter #(.STAGES(2), .MODE(0)) dut_cs (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .d(d8), .q(q_cs), .rco(r_cs));

  typedef struct {
    string      tag;
    logic [3:0] pl, so, eo;
    logic [7:0] cs;
    logic       rpl, rso, reo, rcs;
  } item_t;

  item_t sb[$];
  int compared = 0, mismatched = 0;
  logic [3:0] m_pl = 0, m_so = 0, m_eo = 0;
  logic [7:0] m_cs = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic c, logic l, logic p, logic t,
                      logic [3:0] v4, logic [7:0] v8);
    item_t it;
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; d4 = v4; d8 = v8;
    if (!c) m_pl = 0; else if (!l) m_pl = v4; else if (p && t) m_pl = m_pl + 1;
    if (!c) m_so = 0; else if (!l || (t && m_so == 4'hF)) m_so = v4;
    else if (p && t) m_so = m_so + 1;
    if (!c || m_eo == 4'd13) m_eo = 0; else if (!l) m_eo = v4;
    else if (p && t) m_eo = m_eo + 1;
    if (!c) m_cs = 0; else if (!l) m_cs = v8; else if (p && t) m_cs = m_cs + 1;
    it.tag = tag; it.pl = m_pl; it.so = m_so; it.eo = m_eo; it.cs = m_cs;
    it.rpl = t && m_pl == 4'hF; it.rso = t && m_so == 4'hF;
    it.reo = t && m_eo == 4'hF; it.rcs = t && m_cs == 8'hFF;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.tag, "plain q", {4'h0, q_pl}, {4'h0, e.pl});
        chk(e.tag, "start q", {4'h0, q_so}, {4'h0, e.so});
        chk(e.tag, "end q",   {4'h0, q_eo}, {4'h0, e.eo});
        chk(e.tag, "casc q",  q_cs, e.cs);
        chk(e.tag, "plain rco", {7'h0, r_pl}, {7'h0, e.rpl});
        chk(e.tag, "start rco", {7'h0, r_so}, {7'h0, e.rso});
        chk(e.tag, "end rco",   {7'h0, r_eo}, {7'h0, e.reo});
        chk(e.tag, "casc rco",  {7'h0, r_cs}, {7'h0, e.rcs});
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    step("R1 reset", 0, 1, 1, 1, 4'h5, 8'h55);
    step("R1 reset", 0, 1, 1, 1, 4'h5, 8'h55);
    for (int i = 0; i < 5; i++) step("R3 count", 1, 1, 1, 1, 4'h6, 8'h00);
    for (int i = 0; i < 3; i++) step("R4 P low", 1, 1, 0, 1, 4'h6, 8'h00);
    for (int i = 0; i < 3; i++) step("R4 T low", 1, 1, 1, 0, 4'h6, 8'h00);
    step("R2 load", 1, 0, 0, 0, 4'hA, 8'hA5);
    step("R2 load over count", 1, 0, 1, 1, 4'hC, 8'h3C);
    step("R3 count", 1, 1, 1, 1, 4'h6, 8'h00);
    step("R1 clear over load", 0, 0, 1, 1, 4'h9, 8'h99);
    step("R2 load ones", 1, 0, 0, 0, 4'hF, 8'hFF);
    step("R5 rco with P low", 1, 1, 0, 1, 4'h6, 8'hFF);
    step("R5 rco with T low", 1, 1, 1, 0, 4'h6, 8'hFF);
    for (int i = 0; i < 40; i++) step("R6 R7 R8 run", 1, 1, 1, 1, 4'h6, 8'h00);
    step("R2 load near wrap", 1, 0, 1, 1, 4'h6, 8'hF0);
    for (int i = 0; i < 20; i++) step("R6 wrap", 1, 1, 1, 1, 4'h6, 8'h00);
    step("R8 hold at end", 1, 0, 0, 0, 4'hD, 8'h0D);
    step("R8 clear no enable", 1, 1, 0, 0, 4'h6, 8'h00);
    for (int i = 0; i < 3; i++) step("R3 R7 after", 1, 1, 1, 1, 4'h6, 8'h00);
    repeat (3) @(posedge clk);
    #(PERIOD/2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule